// File: doc/BRIEF.md
# Power-Aware Synchronous Serial Shift Port

This block is an 8-bit synchronous serial port clocked by a shift clock that it generates itself. A programmable divider sets the shift clock rate from the system clock. Software loads a byte into the data register and then sets the run bit. The port drives the byte out on the serial output, most significant bit first, and moves a new byte in from the serial input. When the eighth bit is done, the run bit clears itself, a sticky completion flag is set and an interrupt request pulses. That pulse is what wakes the device from sleep.

The port also watches the device's low-power state. In sleep, a transfer carries on unchanged. In stop, the shift clock and the bit counter freeze. When stop ends, the port does not resume on its own: software must clear the run bit, which aborts the transfer. Clearing the run bit at any point during a transfer returns the port to idle with its bit counter at zero. The next start then sends a freshly loaded byte from its first bit.

Top module: `sio_shift_port`

## Requirements
- R1: A transfer shifts exactly 8 bits, most significant bit first. With the start registered at clock edge E0 and H system cycles per half period, the shift clock falls at edge E0+(2k+1)H, and the serial output then carries transmit bit 7-k, for k = 0 to 7.
- R2: The serial input is sampled at each rising shift clock edge E0+(2k+2)H and shifted into bit 0 of the data register. After completion, the data register holds the 8 received bits, with the first one received in bit 7.
- R3: While no transfer runs, the shift clock is high and the serial output keeps its last driven value. After reset the shift clock is high, the serial output is 1, and the run bit, the flag and the interrupt request are 0.
- R4: Each half period of the shift clock lasts H = clk_div_i + 1 system cycles, which gives a divide ratio of at least 2.
- R5: At the rising edge E0+16H that ends bit 7, the run bit returns to 0, the flag becomes 1 and the interrupt request is 1 for exactly that one cycle.
- R6: The flag stays set until a flag-clear pulse. If a clear and a completion fall in the same cycle, the flag ends up set.
- R7: Sleep mode has no effect on the shift clock timing, the output bits or the received byte.
- R8: Stop mode freezes the shift clock and the bit progress. When stop ends, the port stays frozen with the run bit at 1 until software clears the run bit.
- R9: Clearing the run bit during a transfer takes the port to idle in the next cycle, with the shift clock high and the bit counter at 0. A following start after a reload sends all 8 bits of the new byte.
- R10: While a transfer runs, a data-register load and a start request are both ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div_i | input | 4 | Half-period length minus one, in system cycles |
| load_en_i | input | 1 | Write load_byte_i into the data register when idle |
| load_byte_i | input | 8 | Byte to transmit |
| run_set_i | input | 1 | Set the run bit and start a transfer |
| run_clr_i | input | 1 | Clear the run bit and abort a transfer |
| flag_clr_i | input | 1 | Clear the completion flag |
| sleep_mode_i | input | 1 | Device is in sleep |
| stop_mode_i | input | 1 | Device is in stop |
| sin_i | input | 1 | Serial data input |
| sck_o | output | 1 | Shift clock output, idles high |
| sout_o | output | 1 | Serial data output |
| run_o | output | 1 | Run bit |
| flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | One-cycle interrupt request on completion |
| data_o | output | 8 | Data register contents |

## Verification
Completion of the eighth bit and a software flag clear can land in the same system cycle. Some vectors hold the clear high through the last low phase, so that it is still present at the completion edge. The flag left over from the previous transfer must drop, and at the edge the flag must still read 1 with the interrupt pulsing. A second overlap is a data load and a start request arriving during a transfer. These are held high through the middle bits, and the bench then requires unchanged shift clock timing and a received byte free of the load value.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int unsigned SIO_BITS = 8;
    localparam int unsigned SIO_CW   = $clog2(SIO_BITS);

    typedef struct packed {
        logic              run;
        logic              sck;
        logic [SIO_CW-1:0] bitcnt;
        logic              flag;
        logic              irq;
        logic              frozen;
    } sio_ctl_t;

    typedef struct packed {
        logic [SIO_BITS-1:0] sr;
        logic                sout;
    } sio_shift_t;
endpackage

// File: rtl/sio_divider.sv
module sio_divider #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en && (cnt_q == div);
        cnt_d  = cnt_q;
        if (clear)       cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else if (en)     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: an idle or aborted port restarts its half-period count from zero
    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy,
    input  logic                load_en,
    input  logic [SIO_BITS-1:0] load_data,
    input  logic                fall,
    input  logic                rise,
    input  logic                sin,
    output logic                sout_o,
    output logic [SIO_BITS-1:0] data_o
);
    sio_shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!busy && load_en) sh_d.sr = load_data;
        if (fall)             sh_d.sout = sh_q.sr[SIO_BITS-1];
        if (rise)             sh_d.sr = {sh_q.sr[SIO_BITS-2:0], sin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{sr: '0, sout: 1'b1};
        else        sh_q <= sh_d;
    end

    assign sout_o = sh_q.sout;
    assign data_o = sh_q.sr;

    // R10: a load during a transfer leaves the register untouched
    p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rise) |=> $stable(sh_q.sr));
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port
    import sio_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    clk_div_i,
    input  logic                load_en_i,
    input  logic [SIO_BITS-1:0] load_byte_i,
    input  logic                run_set_i,
    input  logic                run_clr_i,
    input  logic                flag_clr_i,
    input  logic                sleep_mode_i,
    input  logic                stop_mode_i,
    input  logic                sin_i,
    output logic                sck_o,
    output logic                sout_o,
    output logic                run_o,
    output logic                flag_o,
    output logic                irq_o,
    output logic [SIO_BITS-1:0] data_o
);
    localparam logic [SIO_CW-1:0] LAST_BIT = SIO_CW'(SIO_BITS - 1);

    sio_ctl_t ctl_d, ctl_q;
    logic     abort, advance, tick, fall, rise;

    sio_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (advance),
        .clear  (!ctl_q.run || abort),
        .div    (clk_div_i),
        .tick_o (tick)
    );

    sio_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (ctl_q.run),
        .load_en   (load_en_i),
        .load_data (load_byte_i),
        .fall      (fall),
        .rise      (rise),
        .sin       (sin_i),
        .sout_o    (sout_o),
        .data_o    (data_o)
    );

    always_comb begin
        abort   = run_clr_i && ctl_q.run;
        advance = ctl_q.run && !ctl_q.frozen && !stop_mode_i && !run_clr_i;
        fall    = advance && tick && ctl_q.sck;
        rise    = advance && tick && !ctl_q.sck;

        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        if (flag_clr_i) ctl_d.flag = 1'b0;

        if (abort) begin
            ctl_d.run    = 1'b0;
            ctl_d.sck    = 1'b1;
            ctl_d.bitcnt = '0;
            ctl_d.frozen = 1'b0;
        end else if (ctl_q.run) begin
            if (stop_mode_i) ctl_d.frozen = 1'b1;
            if (fall)        ctl_d.sck = 1'b0;
            if (rise) begin
                ctl_d.sck = 1'b1;
                if (ctl_q.bitcnt == LAST_BIT) begin
                    ctl_d.run    = 1'b0;
                    ctl_d.bitcnt = '0;
                    ctl_d.flag   = 1'b1;
                    ctl_d.irq    = 1'b1;
                end else begin
                    ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
                end
            end
        end else if (run_set_i && !run_clr_i) begin
            ctl_d.run    = 1'b1;
            ctl_d.sck    = 1'b1;
            ctl_d.bitcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{run: 1'b0, sck: 1'b1, bitcnt: '0,
                               flag: 1'b0, irq: 1'b0, frozen: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign sck_o  = ctl_q.sck;
    assign run_o  = ctl_q.run;
    assign flag_o = ctl_q.flag;
    assign irq_o  = ctl_q.irq;

    // R1: the serial output only moves together with a falling shift clock
    p_sout_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sout_o) |-> $fell(ctl_q.sck));
    // R5: the interrupt request lasts a single cycle
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.irq |=> !ctl_q.irq);
    // R6: the flag is held until software clears it
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.flag && !flag_clr_i) |=> ctl_q.flag);
    // R7: in sleep a divider tick still toggles the shift clock
    p_sleep_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode_i && advance && tick) |=> (ctl_q.sck != $past(ctl_q.sck)));
    // R8: a frozen port holds its shift clock and bit position
    p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.frozen && !run_clr_i) |=> ($stable(ctl_q.sck) && $stable(ctl_q.bitcnt)));
    // R9: clearing the run bit returns to idle with the counter at zero
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_clr_i && ctl_q.run) |=> (!ctl_q.run && ctl_q.sck && ctl_q.bitcnt == '0));
endmodule

// File: tb/sio_shift_port_test.sv
`timescale 1ns/1ps
module sio_shift_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] clk_div = '0;
    logic       load_en = 1'b0, run_set = 1'b0, run_clr = 1'b0, flag_clr = 1'b0;
    logic       sleep_mode = 1'b0, stop_mode = 1'b0, sin = 1'b0;
    logic [7:0] load_byte = '0;
    logic       sck, sout, run, flag, irq;
    logic [7:0] data;
    int         checks = 0, fails = 0;

    always #2 clk = ~clk;

    sio_shift_port uut (
        .clk(clk), .rst_n(rst_n), .clk_div_i(clk_div), .load_en_i(load_en),
        .load_byte_i(load_byte), .run_set_i(run_set), .run_clr_i(run_clr),
        .flag_clr_i(flag_clr), .sleep_mode_i(sleep_mode), .stop_mode_i(stop_mode),
        .sin_i(sin), .sck_o(sck), .sout_o(sout), .run_o(run), .flag_o(flag),
        .irq_o(irq), .data_o(data)
    );

    // {tx byte, rx byte, clk_div, sleep, flag clear held into completion}
    localparam logic [21:0] VEC [8] = '{
        {8'hA5, 8'h3C, 4'd0, 1'b0, 1'b0},
        {8'h5A, 8'hC3, 4'd1, 1'b0, 1'b1},
        {8'hFF, 8'h00, 4'd2, 1'b1, 1'b0},
        {8'h00, 8'hFF, 4'd3, 1'b0, 1'b1},
        {8'h81, 8'h7E, 4'd0, 1'b1, 1'b1},
        {8'h96, 8'h69, 4'd1, 1'b1, 1'b0},
        {8'h01, 8'h80, 4'd2, 1'b0, 1'b0},
        {8'hE7, 8'h18, 4'd0, 1'b0, 1'b1}
    };

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load(logic [7:0] b);
        load_byte = b; load_en = 1'b1;
        step(1);
        load_en = 1'b0;
    endtask

    task automatic run_xfer(logic [7:0] tx, logic [7:0] rx, logic [3:0] dv, bit slp, bit clr_end);
        int h;
        h = int'(dv) + 1;
        clk_div = dv; sleep_mode = slp;
        load(tx);
        chk(data == tx, "R10 idle load", data, tx);
        run_set = 1'b1;
        step(1);
        run_set = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step(h);
            chk(sck == 1'b0, "R4 sck low phase", sck, 0);
            chk(sout == tx[7-k], "R1 sout bit", sout, tx[7-k]);
            sin = rx[7-k];
            if (k == 3) begin
                load_en = 1'b1; load_byte = ~tx; run_set = 1'b1;
            end
            if (k == 7 && clr_end) flag_clr = 1'b1;
            step(h);
            load_en = 1'b0; run_set = 1'b0; flag_clr = 1'b0;
            if (k < 7) begin
                chk(sck == 1'b1, "R4 sck high phase", sck, 1);
                chk(run == 1'b1, "R7 run during transfer", run, 1);
            end
        end
        chk(run == 1'b0, "R5 run self-clear", run, 0);
        chk(flag == 1'b1, "R6 flag set at completion", flag, 1);
        chk(irq == 1'b1, "R5 irq at completion", irq, 1);
        chk(data == rx, "R2 received byte", data, rx);
        chk(sck == 1'b1, "R3 sck idle", sck, 1);
        step(1);
        chk(irq == 1'b0, "R5 irq one cycle", irq, 0);
        chk(sout == tx[0], "R3 sout holds", sout, tx[0]);
        sleep_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(sck == 1'b1, "R3 reset sck", sck, 1);
        chk(sout == 1'b1, "R3 reset sout", sout, 1);
        chk(run == 1'b0, "R3 reset run", run, 0);
        chk(flag == 1'b0, "R3 reset flag", flag, 0);
        chk(irq == 1'b0, "R3 reset irq", irq, 0);

        for (int v = 0; v < 8; v++)
            run_xfer(VEC[v][21:14], VEC[v][13:6], VEC[v][5:2], VEC[v][1], VEC[v][0]);

        // R6: flag persists until cleared
        step(5);
        chk(flag == 1'b1, "R6 flag sticky", flag, 1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk(flag == 1'b0, "R6 flag cleared", flag, 0);

        // R8: stop freezes, no automatic resume
        clk_div = 4'd1;
        load(8'hA5);
        run_set = 1'b1; step(1); run_set = 1'b0;
        step(6);
        chk(sck == 1'b0, "R8 low phase before stop", sck, 0);
        stop_mode = 1'b1;
        step(5);
        chk(sck == 1'b0, "R8 sck frozen in stop", sck, 0);
        chk(run == 1'b1, "R8 run held in stop", run, 1);
        stop_mode = 1'b0;
        step(10);
        chk(sck == 1'b0, "R8 no resume after stop", sck, 0);
        chk(run == 1'b1, "R8 run still set", run, 1);
        chk(irq == 1'b0, "R8 no completion", irq, 0);
        run_clr = 1'b1; step(1); run_clr = 1'b0;
        chk(run == 1'b0, "R9 abort after stop", run, 0);
        chk(sck == 1'b1, "R9 sck idle after abort", sck, 1);
        run_xfer(8'h3C, 8'hA6, 4'd1, 1'b0, 1'b0);

        // R9: abort mid transfer, restart sends fresh byte
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        clk_div = 4'd0;
        load(8'hF0);
        run_set = 1'b1; step(1); run_set = 1'b0;
        step(5);
        run_clr = 1'b1; step(1); run_clr = 1'b0;
        chk(run == 1'b0, "R9 abort mid transfer", run, 0);
        chk(sck == 1'b1, "R9 sck high after abort", sck, 1);
        chk(flag == 1'b0, "R9 no flag on abort", flag, 0);
        step(4);
        chk(sck == 1'b1, "R9 idle stays idle", sck, 1);
        run_xfer(8'h4B, 8'h2D, 4'd0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule